// File: doc/BRIEF.md
# Half-Bridge Gate Command Supervisor

This block sits between a controller's four logic-level gate commands (power-factor stage, half-bridge low side, half-bridge high side, filament heater) and the four gate-drive outputs. It passes commands through only while the controller reports operating mode and the supply is above its undervoltage lockout. In every other state it holds all four gates low.

Inside operating mode it also guards the half-bridge. A current-sense comparator flag sets a fault latch. The latch blanks both half-bridge gates and raises a fault output. The latch releases only when both half-bridge commands are low in the same cycle and the sense flag has dropped, or when the supply falls below lockout. A cross-conduction interlock blanks both half-bridge gates for as long as both commands are high together.

All outputs are registered. A condition sampled at a clock edge shows at the outputs directly after that edge.

Top module: `hb_gate_supervisor`

## Requirements
- R1: While `op_mode` is low or `uvlo` is high at a clock edge, all four gate outputs and `fault_out` are low after that edge.
- R2: Every output is registered. After edge k, the outputs reflect the inputs sampled at edge k, with no combinational path from input to output.
- R3: With `op_mode` high, `uvlo` low and `sense_trip` high at an edge, `fault_out` is high and `gate_lo` and `gate_hi` are low after that edge.
- R4: A set latch clears at an edge where `op_mode` is high, `uvlo` is low, `cmd_lo` and `cmd_hi` are both low and `sense_trip` is low. `fault_out` is then low after that edge. If `sense_trip` is high in that cycle, the latch stays set.
- R5: While the latch is set and the clear condition of R4 is not met, `fault_out` stays high and `gate_lo` and `gate_hi` stay low, whatever the commands are.
- R6: A cycle with `uvlo` high clears the latch. When operating mode resumes with `sense_trip` low, `fault_out` is low.
- R7: `sense_trip` has no effect outside operating mode. A trip seen while `op_mode` is low does not set the latch.
- R8: With `cmd_lo` and `cmd_hi` both high at an edge, `gate_lo` and `gate_hi` are both low after that edge. With exactly one of them high and no fault, that gate follows its command.
- R9: In operating mode, `gate_pfc` and `gate_heat` follow their commands regardless of the fault latch and the interlock.
- R10: Leaving operating mode without `uvlo` keeps the latch state, although `fault_out` reads low meanwhile. On return to operating mode with the half-bridge commands not both low, `fault_out` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 1 | Controller reports operating mode |
| uvlo | input | 1 | Supply below undervoltage lockout |
| cmd_pfc | input | 1 | Power-factor stage command |
| cmd_lo | input | 1 | Half-bridge low-side command |
| cmd_hi | input | 1 | Half-bridge high-side command |
| cmd_heat | input | 1 | Filament heater command |
| sense_trip | input | 1 | Over-current comparator flag |
| gate_pfc | output | 1 | Power-factor gate |
| gate_lo | output | 1 | Low-side gate |
| gate_hi | output | 1 | High-side gate |
| gate_heat | output | 1 | Heater gate |
| fault_out | output | 1 | Latched over-current indication |

## Verification
The properties assume that every input is a clean synchronous level, stable around each rising edge. They also assume that `op_mode` and `uvlo` may change in any cycle, with no ordering between them. The bench drives all inputs at the falling edge and walks every one of the 128 combinations of the seven control inputs several times, in a scrambled order. This reaches each combination from both a set and a clear latch. Short directed sequences then cover lockout clearing, ignored trips outside operating mode, and the latch being held across a mode exit.

// File: rtl/hbgs_pkg.sv
package hbgs_pkg;
  localparam int unsigned NUM_GATES = 4;

  typedef struct packed {
    logic pfc;
    logic lo;
    logic hi;
    logic heat;
  } gate_vec_t;

  localparam gate_vec_t GATES_OFF = '{pfc: 1'b0, lo: 1'b0, hi: 1'b0, heat: 1'b0};
endpackage

// File: rtl/hbgs_fault_latch.sv
module hbgs_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic uvlo,
  input  logic trip,
  input  logic cmd_lo,
  input  logic cmd_hi,
  output logic fault_nxt,
  output logic fault_q
);
  logic release_ok;

  // Release needs both half-bridge commands idle and the flag gone.
  always_comb begin
    release_ok = ~cmd_lo & ~cmd_hi & ~trip;
    fault_nxt  = fault_q;
    if (uvlo) begin
      fault_nxt = 1'b0;
    end else if (active) begin
      if (trip) begin
        fault_nxt = 1'b1;
      end else if (fault_q && release_ok) begin
        fault_nxt = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
    end else begin
      fault_q <= fault_nxt;
    end
  end
endmodule

// File: rtl/hbgs_gate_logic.sv
module hbgs_gate_logic
  import hbgs_pkg::*;
(
  input  gate_vec_t cmd,
  input  logic      active,
  input  logic      fault_nxt,
  input  logic      overlap_blank,
  output gate_vec_t gate_nxt,
  output logic      flag_nxt
);
  logic hb_allow;

  always_comb begin
    hb_allow = active & ~fault_nxt & ~overlap_blank;
    gate_nxt = GATES_OFF;
    if (active) begin
      gate_nxt.pfc  = cmd.pfc;
      gate_nxt.heat = cmd.heat;
    end
    gate_nxt.lo = cmd.lo & hb_allow;
    gate_nxt.hi = cmd.hi & hb_allow;
    flag_nxt    = active & fault_nxt;
  end
endmodule

// File: rtl/hbgs_out_reg.sv
module hbgs_out_reg #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[i] <= 1'b0;
      end else begin
        q[i] <= d[i];
      end
    end
  end
endmodule

// File: rtl/hb_gate_supervisor.sv
module hb_gate_supervisor
  import hbgs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic op_mode,
  input  logic uvlo,
  input  logic cmd_pfc,
  input  logic cmd_lo,
  input  logic cmd_hi,
  input  logic cmd_heat,
  input  logic sense_trip,
  output logic gate_pfc,
  output logic gate_lo,
  output logic gate_hi,
  output logic gate_heat,
  output logic fault_out
);
  localparam int unsigned OUT_W = NUM_GATES + 1;

  logic        active;
  logic        overlap_blank;
  logic        fault_nxt;
  logic        fault_q;
  logic        flag_nxt;
  gate_vec_t   cmd;
  gate_vec_t   gate_nxt;
  logic [OUT_W-1:0] out_d;
  logic [OUT_W-1:0] out_q;

  always_comb begin
    active        = op_mode & ~uvlo;
    overlap_blank = cmd_lo & cmd_hi;
    cmd           = '{pfc: cmd_pfc, lo: cmd_lo, hi: cmd_hi, heat: cmd_heat};
  end

  hbgs_fault_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .uvlo      (uvlo),
    .trip      (sense_trip),
    .cmd_lo    (cmd_lo),
    .cmd_hi    (cmd_hi),
    .fault_nxt (fault_nxt),
    .fault_q   (fault_q)
  );

  hbgs_gate_logic u_gates (
    .cmd           (cmd),
    .active        (active),
    .fault_nxt     (fault_nxt),
    .overlap_blank (overlap_blank),
    .gate_nxt      (gate_nxt),
    .flag_nxt      (flag_nxt)
  );

  assign out_d = {flag_nxt, gate_nxt};

  hbgs_out_reg #(.WIDTH(OUT_W)) u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (out_d),
    .q     (out_q)
  );

  assign {fault_out, gate_pfc, gate_lo, gate_hi, gate_heat} = out_q;
endmodule

// File: rtl/hb_gate_supervisor_chk.sv
module hb_gate_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic op_mode,
  input logic uvlo,
  input logic cmd_pfc,
  input logic cmd_lo,
  input logic cmd_hi,
  input logic cmd_heat,
  input logic sense_trip,
  input logic gate_pfc,
  input logic gate_lo,
  input logic gate_hi,
  input logic gate_heat,
  input logic fault_out
);
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_mode || uvlo) |=> (!gate_pfc && !gate_lo && !gate_hi && !gate_heat && !fault_out));

  p_trip_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode && !uvlo && sense_trip) |=> (fault_out && !gate_lo && !gate_hi));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_out && op_mode && !uvlo && !sense_trip && !cmd_lo && !cmd_hi) |=> !fault_out);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_out && op_mode && !uvlo && (cmd_lo || cmd_hi)) |=> (fault_out && !gate_lo && !gate_hi));

  p_uvlo_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode && !uvlo && !sense_trip && $past(uvlo)) |=> !fault_out);

  p_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lo && cmd_hi) |=> (!gate_lo && !gate_hi));

  p_aux_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode && !uvlo) |=> (gate_pfc == $past(cmd_pfc) && gate_heat == $past(cmd_heat)));

  p_hb_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_lo && gate_hi));
endmodule

bind hb_gate_supervisor hb_gate_supervisor_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_mode    (op_mode),
  .uvlo       (uvlo),
  .cmd_pfc    (cmd_pfc),
  .cmd_lo     (cmd_lo),
  .cmd_hi     (cmd_hi),
  .cmd_heat   (cmd_heat),
  .sense_trip (sense_trip),
  .gate_pfc   (gate_pfc),
  .gate_lo    (gate_lo),
  .gate_hi    (gate_hi),
  .gate_heat  (gate_heat),
  .fault_out  (fault_out)
);

// File: tb/sim_hb_gate_supervisor.sv
module sim_hb_gate_supervisor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_mode = 1'b0, uvlo = 1'b0, cmd_pfc = 1'b0, cmd_lo = 1'b0;
  logic cmd_hi = 1'b0, cmd_heat = 1'b0, sense_trip = 1'b0;
  logic gate_pfc, gate_lo, gate_hi, gate_heat, fault_out;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic m_fault = 1'b0;

  always #10 clk = ~clk;

  hb_gate_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .uvlo(uvlo),
    .cmd_pfc(cmd_pfc), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .cmd_heat(cmd_heat),
    .sense_trip(sense_trip), .gate_pfc(gate_pfc), .gate_lo(gate_lo),
    .gate_hi(gate_hi), .gate_heat(gate_heat), .fault_out(fault_out)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  // vec bits: 6 op_mode, 5 uvlo, 4 pfc, 3 lo, 2 hi, 1 heat, 0 sense
  task automatic step(input logic [6:0] v, input string force_tag);
    logic act_m, nf;
    string t_hb, t_f, t_aux;
    @(negedge clk);
    {op_mode, uvlo, cmd_pfc, cmd_lo, cmd_hi, cmd_heat, sense_trip} = v;
    act_m = v[6] & ~v[5];
    if (v[5]) nf = 1'b0;
    else if (!act_m) nf = m_fault;
    else if (v[0]) nf = 1'b1;
    else if (!v[3] && !v[2]) nf = 1'b0;
    else nf = m_fault;
    if (!act_m) begin t_hb = "R1"; t_f = "R1"; t_aux = "R1"; end
    else begin
      t_aux = "R9";
      t_hb  = (v[3] && v[2]) ? "R8" : (nf ? "R5" : "R2");
      t_f   = v[0] ? "R3" : (m_fault ? (nf ? "R5" : "R4") : "R2");
    end
    if (force_tag != "") begin t_hb = force_tag; t_f = force_tag; end
    @(posedge clk);
    #1;
    m_fault = nf;
    check(t_aux, "gate_pfc",  gate_pfc,  act_m & v[4]);
    check(t_aux, "gate_heat", gate_heat, act_m & v[1]);
    check(t_hb,  "gate_lo",   gate_lo,   act_m & v[3] & ~v[2] & ~nf);
    check(t_hb,  "gate_hi",   gate_hi,   act_m & v[2] & ~v[3] & ~nf);
    check(t_f,   "fault_out", fault_out, act_m & nf);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset gate_lo", gate_lo, 1'b0);
    check("R1", "reset fault_out", fault_out, 1'b0);
    rst_n = 1'b1;

    // Exhaustive sweeps in a scrambled order (odd multiplier is a bijection mod 128).
    for (int pass = 0; pass < 4; pass++) begin
      for (int i = 0; i < 128; i++) begin
        step(7'((i * (37 + 2 * pass) + pass * 11) & 127), "");
      end
    end

    // R6: lockout clears a set latch
    step(7'b1000101, "R3");
    step(7'b1101000, "R6");
    step(7'b1001000, "R6");
    // R7: trip ignored outside operating mode
    step(7'b0000001, "R7");
    step(7'b1001000, "R7");
    // R10: latch held across mode exit
    step(7'b1000001, "R3");
    step(7'b0001000, "R10");
    step(7'b1000100, "R10");
    // R4: release refused while flag still high, then granted
    step(7'b1000001, "R4");
    step(7'b1000000, "R4");
    // R2: single-side commands pass with one cycle of latency
    step(7'b1001000, "R2");
    step(7'b1000100, "R2");
    step(7'b1010010, "R9");

    finish_run();
  end
endmodule